// File: doc/BRIEF.md
# Sound RAM Transfer FIFO Controller

This block moves 16-bit halfwords between a sound sample RAM and a host. A 32-entry halfword FIFO sits between the two sides. A pacing engine moves at most one halfword between the FIFO and the RAM in each fixed slot of clock ticks. A two-bit mode selects the direction and the source. Stopped leaves everything idle. Manual write takes halfwords from a data-register port and drains them to RAM. DMA write takes 32-bit words from the host and drains them to RAM. DMA read fills the FIFO from RAM so that the host can take the data as 32-bit words.

The host DMA engine watches three request flags. They follow the FIFO's full or empty state for the active direction. The transfer pointer is a halfword index into RAM. It steps by one halfword (two bytes) after every RAM access and wraps at the top of RAM. Leaving any mode for stopped flushes the FIFO. Host data that does not fit is dropped. A host read that finds the FIFO short is padded with the last halfword handed out.

Top module: `snd_xfer_ctrl`

## Requirements
- R1: After reset the FIFO is empty, the transfer pointer is 0 and the mode is stopped (0). busy, dma_req, dma_rd_req, dma_wr_req and ram_en are all low.
- R2: The engine moves at most one halfword per slot of TICKS (default 32) cycles. The first RAM access comes TICKS cycles after the clock edge at which work appears. Back-to-back accesses are exactly TICKS cycles apart.
- R3: mode_in encodes 0 = stopped, 1 = manual write, 2 = DMA write and 3 = DMA read, and takes effect on a mode_wr cycle. In modes 0 and 1, dma_req, dma_rd_req and dma_wr_req stay low. In modes 2 and 3, dma_req equals dma_rd_req OR dma_wr_req.
- R4: In mode 3 the engine reads RAM into the FIFO until the FIFO holds DEPTH halfwords. dma_rd_req is high exactly while the FIFO is full.
- R5: In modes 1 and 2 the engine writes FIFO entries to RAM in arrival order until the FIFO is empty. In mode 2, dma_wr_req is high exactly while the FIFO is empty.
- R6: Each RAM access uses ram_addr equal to the transfer pointer. The pointer then advances by one halfword, modulo 2^HW_ADDR_W. A cycle with addr_wr loads the pointer from addr_in.
- R7: A mode_wr that changes the mode from nonzero to 0 empties the FIFO. Data queued before it never reaches RAM.
- R8: A data_wr halfword is queued only in mode 1, and only while the FIFO is not full. Otherwise it is dropped.
- R9: In mode 2 a dma_wr_en word queues bits [15:0] first and bits [31:16] second. When only one entry is free, only bits [15:0] are kept. When none is free, the word is dropped. dma_wr_en has no effect in any other mode.
- R10: dma_rd_data gives the word that a dma_rd_en cycle in mode 3 takes. With two or more entries it holds {second, first}. With one entry it holds {first, first}. With none it holds {pad, pad}. pad is the last halfword taken, or 0 if none has been taken since reset or the last flush.
- R11: busy is high exactly when the mode is 3 and the FIFO is not full, or the mode is 1 or 2 and the FIFO is not empty.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mode_wr | input | 1 | Load mode_in into the mode register |
| mode_in | input | 2 | New transfer mode |
| addr_wr | input | 1 | Load addr_in into the transfer pointer |
| addr_in | input | HW_ADDR_W | New transfer pointer (halfword index) |
| data_wr | input | 1 | Manual halfword write strobe |
| data_in | input | 16 | Manual halfword |
| dma_wr_en | input | 1 | Host delivers one 32-bit word |
| dma_wr_data | input | 32 | Host write word |
| dma_rd_en | input | 1 | Host takes one 32-bit word |
| dma_rd_data | output | 32 | Word the host takes on dma_rd_en |
| dma_req | output | 1 | Combined DMA request |
| dma_rd_req | output | 1 | FIFO full in DMA read mode |
| dma_wr_req | output | 1 | FIFO empty in DMA write mode |
| busy | output | 1 | Transfer engine has work pending |
| ram_en | output | 1 | RAM access strobe |
| ram_we | output | 1 | RAM access is a write |
| ram_addr | output | HW_ADDR_W | RAM halfword address |
| ram_wdata | output | 16 | RAM write data |
| ram_rdata | input | 16 | RAM read data, one cycle after a read |

## Verification
A FIFO count that is off by one shows up at the ports within a single transfer. A missing or repeated halfword appears in RAM or on dma_rd_data, and busy or a request flag moves one slot early or late. A pacing counter that slips shows as a RAM-access spacing other than TICKS, visible on the second access. A pointer error shows on ram_addr at the next access, and most plainly where the pointer crosses the top of RAM. A stale pad register or a missed flush shows on the first underflowing host read after a stop.

// File: rtl/snd_xfer_pkg.sv
package snd_xfer_pkg;

  typedef enum logic [1:0] {
    XM_STOP   = 2'd0,
    XM_MANUAL = 2'd1,
    XM_DMA_WR = 2'd2,
    XM_DMA_RD = 2'd3
  } xfer_mode_e;

  // modes in which the engine empties the FIFO into RAM
  function automatic logic drains_to_ram(xfer_mode_e m);
    return (m == XM_MANUAL) || (m == XM_DMA_WR);
  endfunction

  // host word layout: earlier halfword in the low half
  function automatic logic [31:0] pack_pair(logic [15:0] first, logic [15:0] second);
    return {second, first};
  endfunction

  // how many halfwords of a host word fit into the free space
  function automatic logic [1:0] fit_of(int unsigned free_slots);
    return (free_slots >= 2) ? 2'd2 : 2'(free_slots);
  endfunction

endpackage

// File: rtl/snd_xfer_fifo.sv
module snd_xfer_fifo #(
  parameter int DEPTH = 32,          // power of two
  parameter int W     = 16,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          flush,
  input  logic [1:0]    push_n,
  input  logic [W-1:0]  push_d0,
  input  logic [W-1:0]  push_d1,
  input  logic [1:0]    pop_n,
  output logic [W-1:0]  head0,
  output logic [W-1:0]  head1,
  output logic [CW-1:0] count
);
  localparam int PW = $clog2(DEPTH);

  logic [W-1:0]  mem [DEPTH];
  logic [PW-1:0] wp, rp;
  logic [PW-1:0] wp_nx1, rp_nx1;

  assign wp_nx1 = PW'(wp + 1'b1);
  assign rp_nx1 = PW'(rp + 1'b1);

  always_ff @(posedge clk) begin
    if (!flush) begin
      if (push_n != 2'd0) mem[wp] <= push_d0;
      if (push_n == 2'd2) mem[wp_nx1] <= push_d1;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n || flush) begin
      wp    <= '0;
      rp    <= '0;
      count <= '0;
    end else begin
      wp    <= PW'(wp + PW'(push_n));
      rp    <= PW'(rp + PW'(pop_n));
      count <= CW'(count + CW'(push_n) - CW'(pop_n));
    end
  end

  assign head0 = mem[rp];
  assign head1 = mem[rp_nx1];

  AST_NO_OVERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(push_n) + int'(count) <= DEPTH)); // R9
  AST_NO_UNDERFLOW: assert property (@(posedge clk) disable iff (!rst_n)
    !flush |-> (int'(pop_n) <= int'(count))); // R10
  AST_FLUSH_EMPTIES: assert property (@(posedge clk) disable iff (!rst_n)
    flush |=> (count == '0)); // R7
endmodule

// File: rtl/snd_xfer_pacer.sv
module snd_xfer_pacer #(
  parameter int TICKS = 32   // at least 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  output logic fire
);
  localparam int TW = (TICKS > 1) ? $clog2(TICKS) : 1;
  localparam logic [TW-1:0] LAST = TW'(TICKS - 1);

  logic [TW-1:0] tick;

  assign fire = run && (tick == LAST);

  always_ff @(posedge clk) begin
    if (!rst_n || !run || fire) tick <= '0;
    else                        tick <= TW'(tick + 1'b1);
  end
endmodule

// File: rtl/snd_xfer_dma_pack.sv
module snd_xfer_dma_pack
  import snd_xfer_pkg::*;
#(
  parameter int DEPTH = 32,
  parameter int CW    = $clog2(DEPTH + 1)
) (
  input  logic [CW-1:0] count,
  input  logic [15:0]   head0,
  input  logic [15:0]   head1,
  input  logic [15:0]   pad,
  output logic [31:0]   rd_word,
  output logic [1:0]    rd_take,
  output logic [1:0]    wr_fit
);
  always_comb begin
    if (count >= CW'(2)) begin
      rd_word = pack_pair(head0, head1);
      rd_take = 2'd2;
    end else if (count == CW'(1)) begin
      rd_word = pack_pair(head0, head0);
      rd_take = 2'd1;
    end else begin
      rd_word = pack_pair(pad, pad);
      rd_take = 2'd0;
    end
  end

  assign wr_fit = fit_of(int'(DEPTH) - int'(count));
endmodule

// File: rtl/snd_xfer_ctrl.sv
module snd_xfer_ctrl
  import snd_xfer_pkg::*;
#(
  parameter int DEPTH     = 32,
  parameter int TICKS     = 32,
  parameter int HW_ADDR_W = 18
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic                 mode_wr,
  input  logic [1:0]           mode_in,
  input  logic                 addr_wr,
  input  logic [HW_ADDR_W-1:0] addr_in,
  input  logic                 data_wr,
  input  logic [15:0]          data_in,
  input  logic                 dma_wr_en,
  input  logic [31:0]          dma_wr_data,
  input  logic                 dma_rd_en,
  output logic [31:0]          dma_rd_data,
  output logic                 dma_req,
  output logic                 dma_rd_req,
  output logic                 dma_wr_req,
  output logic                 busy,
  output logic                 ram_en,
  output logic                 ram_we,
  output logic [HW_ADDR_W-1:0] ram_addr,
  output logic [15:0]          ram_wdata,
  input  logic [15:0]          ram_rdata
);
  localparam int CW = $clog2(DEPTH + 1);
  localparam logic [CW-1:0] FULL_LVL = CW'(DEPTH);

  function automatic logic [HW_ADDR_W-1:0] step_addr(logic [HW_ADDR_W-1:0] a);
    return HW_ADDR_W'(a + 1'b1);
  endfunction

  xfer_mode_e           mode_q;
  logic [HW_ADDR_W-1:0] addr_q;
  logic [15:0]          pad_q;
  logic                 rd_pend;

  // named internal events
  logic          flush;
  logic          fifo_full, fifo_empty;
  logic          fire, eng_read, eng_write, host_take;
  logic [CW-1:0] level;
  logic [15:0]   head0, head1;
  logic [1:0]    push_n, pop_n, rd_take, wr_fit;
  logic [15:0]   push_d0, push_d1;
  logic [31:0]   rd_word;

  assign flush      = mode_wr && (xfer_mode_e'(mode_in) == XM_STOP) && (mode_q != XM_STOP);
  assign fifo_full  = (level == FULL_LVL);
  assign fifo_empty = (level == '0);

  assign busy = ((mode_q == XM_DMA_RD) && !fifo_full) ||
                (drains_to_ram(mode_q) && !fifo_empty);

  snd_xfer_pacer #(.TICKS(TICKS)) u_pacer (
    .clk  (clk),
    .rst_n(rst_n),
    .run  (busy),
    .fire (fire)
  );

  assign eng_read  = fire && (mode_q == XM_DMA_RD);
  assign eng_write = fire && drains_to_ram(mode_q);
  assign host_take = (mode_q == XM_DMA_RD) && dma_rd_en && !flush && (rd_take != 2'd0);

  assign ram_en    = eng_read || eng_write;
  assign ram_we    = eng_write;
  assign ram_addr  = addr_q;
  assign ram_wdata = head0;

  snd_xfer_dma_pack #(.DEPTH(DEPTH), .CW(CW)) u_pack (
    .count  (level),
    .head0  (head0),
    .head1  (head1),
    .pad    (pad_q),
    .rd_word(rd_word),
    .rd_take(rd_take),
    .wr_fit (wr_fit)
  );

  assign dma_rd_data = rd_word;

  // FIFO source and sink per mode
  always_comb begin
    push_n  = 2'd0;
    push_d0 = '0;
    push_d1 = '0;
    pop_n   = 2'd0;
    unique case (mode_q)
      XM_MANUAL: begin
        if (data_wr && !fifo_full) begin
          push_n  = 2'd1;
          push_d0 = data_in;
        end
        if (eng_write) pop_n = 2'd1;
      end
      XM_DMA_WR: begin
        if (dma_wr_en) begin
          push_n  = wr_fit;
          push_d0 = dma_wr_data[15:0];
          push_d1 = dma_wr_data[31:16];
        end
        if (eng_write) pop_n = 2'd1;
      end
      XM_DMA_RD: begin
        if (rd_pend) begin
          push_n  = 2'd1;
          push_d0 = ram_rdata;
        end
        if (dma_rd_en) pop_n = rd_take;
      end
      default: ;
    endcase
  end

  snd_xfer_fifo #(.DEPTH(DEPTH), .W(16), .CW(CW)) u_fifo (
    .clk    (clk),
    .rst_n  (rst_n),
    .flush  (flush),
    .push_n (push_n),
    .push_d0(push_d0),
    .push_d1(push_d1),
    .pop_n  (pop_n),
    .head0  (head0),
    .head1  (head1),
    .count  (level)
  );

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      mode_q  <= XM_STOP;
      addr_q  <= '0;
      pad_q   <= '0;
      rd_pend <= 1'b0;
    end else begin
      if (mode_wr) mode_q <= xfer_mode_e'(mode_in);
      if (addr_wr)     addr_q <= addr_in;
      else if (ram_en) addr_q <= step_addr(addr_q);
      if (flush)          pad_q <= '0;
      else if (host_take) pad_q <= (rd_take == 2'd2) ? head1 : head0;
      rd_pend <= eng_read && !flush;
    end
  end

  assign dma_rd_req = (mode_q == XM_DMA_RD) && fifo_full;
  assign dma_wr_req = (mode_q == XM_DMA_WR) && fifo_empty;
  assign dma_req    = dma_rd_req || dma_wr_req;

  AST_ONE_PER_SLOT: assert property (@(posedge clk) disable iff (!rst_n)
    ram_en |=> !ram_en); // R2
  AST_ADDR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !addr_wr) |=> (ram_addr == HW_ADDR_W'($past(ram_addr) + 1'b1))); // R6
  AST_STOP_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (mode_q == XM_STOP) |-> (!ram_en && !dma_req && !busy)); // R3
  AST_READ_HAS_ROOM: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_en && !ram_we) |-> !fifo_full); // R4
  AST_WRITE_HAS_DATA: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> !fifo_empty); // R5
  AST_REQ_EXCLUSIVE: assert property (@(posedge clk) disable iff (!rst_n)
    $onehot0({dma_rd_req, dma_wr_req})); // R3
endmodule

// File: tb/snd_xfer_ctrl_test.sv
module snd_xfer_ctrl_test;
  localparam int DEPTH = 32;
  localparam int TICKS = 32;
  localparam int AW    = 9;
  localparam int RSZ   = 1 << AW;
  localparam int LIMIT = 150000;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic mode_wr = 1'b0, addr_wr = 1'b0, data_wr = 1'b0;
  logic dma_wr_en = 1'b0, dma_rd_en = 1'b0;
  logic [1:0]    mode_in = '0;
  logic [AW-1:0] addr_in = '0;
  logic [15:0]   data_in = '0;
  logic [31:0]   dma_wr_data = '0;
  logic [31:0]   dma_rd_data;
  logic dma_req, dma_rd_req, dma_wr_req, busy, ram_en, ram_we;
  logic [AW-1:0] ram_addr;
  logic [15:0]   ram_wdata;
  logic [15:0]   ram_rdata = '0;

  always #5 clk = ~clk;

  snd_xfer_ctrl #(.DEPTH(DEPTH), .TICKS(TICKS), .HW_ADDR_W(AW)) uut (
    .clk(clk), .rst_n(rst_n), .mode_wr(mode_wr), .mode_in(mode_in),
    .addr_wr(addr_wr), .addr_in(addr_in), .data_wr(data_wr), .data_in(data_in),
    .dma_wr_en(dma_wr_en), .dma_wr_data(dma_wr_data), .dma_rd_en(dma_rd_en),
    .dma_rd_data(dma_rd_data), .dma_req(dma_req), .dma_rd_req(dma_rd_req),
    .dma_wr_req(dma_wr_req), .busy(busy), .ram_en(ram_en), .ram_we(ram_we),
    .ram_addr(ram_addr), .ram_wdata(ram_wdata), .ram_rdata(ram_rdata)
  );

  // RAM model and access logs
  logic [15:0]   bram [RSZ];
  logic          pre_en = 1'b0, log_clr = 1'b0;
  logic [AW-1:0] pre_a = '0;
  logic [15:0]   pre_d = '0;
  int            cyc = 0, wn = 0, rn = 0;
  logic [15:0]   wlog_d [64];
  int            wlog_a [64];
  int            wlog_c [64];
  int            rlog_c [64];

  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (pre_en) bram[pre_a] <= pre_d;
    if (ram_en) begin
      if (ram_we) bram[ram_addr] <= ram_wdata;
      else        ram_rdata <= bram[ram_addr];
    end
    if (log_clr) begin
      wn <= 0;
      rn <= 0;
    end else if (ram_en) begin
      if (ram_we) begin
        if (wn < 64) begin
          wlog_d[wn] <= ram_wdata;
          wlog_a[wn] <= int'(ram_addr);
          wlog_c[wn] <= cyc;
        end
        wn <= wn + 1;
      end else begin
        if (rn < 64) rlog_c[rn] <= cyc;
        rn <= rn + 1;
      end
    end
  end

  int n_tests = 0, n_fail = 0;
  logic timed_out = 1'b0;

  task automatic chk(string req, string what, logic [31:0] act, logic [31:0] exp);
    n_tests++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
    end
  endtask

  function automatic int hw_at(int base, int k);
    return (base + k) % RSZ;
  endfunction

  function automatic logic [31:0] word_of(logic [15:0] lo, logic [15:0] hi);
    return {hi, lo};
  endfunction

  task automatic set_mode(logic [1:0] m);
    @(negedge clk); mode_wr = 1'b1; mode_in = m;
    @(negedge clk); mode_wr = 1'b0;
  endtask

  task automatic set_addr(int a);
    @(negedge clk); addr_wr = 1'b1; addr_in = AW'(a);
    @(negedge clk); addr_wr = 1'b0;
  endtask

  task automatic clr_logs();
    @(negedge clk); log_clr = 1'b1;
    @(negedge clk); log_clr = 1'b0;
  endtask

  task automatic preload(int a, logic [15:0] d);
    @(negedge clk); pre_en = 1'b1; pre_a = AW'(a); pre_d = d;
    @(negedge clk); pre_en = 1'b0;
  endtask

  task automatic wait_idle(int cap);
    for (int i = 0; i < cap; i++) begin
      @(negedge clk);
      if (!busy) break;
    end
  endtask

  task automatic wait_rd_req(int cap);
    for (int i = 0; i < cap; i++) begin
      @(negedge clk);
      if (dma_rd_req) break;
    end
  endtask

  task automatic run_all();
    logic [31:0] w [17];
    logic [31:0] lone;
    logic [15:0] v [33];
    logic [15:0] p [32];
    logic [15:0] q0;
    int c0, bad;

    void'($urandom(32'h5EED_1234));
    // R1: reset state
    repeat (4) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1", "busy after reset", 32'(busy), 0);
    chk("R1", "requests after reset", {dma_req, dma_rd_req, dma_wr_req}, 0);
    chk("R1", "ram_en after reset", 32'(ram_en), 0);

    // DMA write: overflow, single-slot fit, order, pacing, address from 0
    set_mode(2'd2);
    chk("R5", "wr_req while empty", 32'(dma_wr_req), 1);
    chk("R3", "dma_req in mode 2", 32'(dma_req), 1);
    chk("R11", "busy empty mode 2", 32'(busy), 0);
    clr_logs();
    for (int i = 0; i < 17; i++) begin
      w[i] = $urandom;
      @(negedge clk); dma_wr_en = 1'b1; dma_wr_data = w[i];
    end
    @(negedge clk); dma_wr_en = 1'b0;
    chk("R11", "busy with data", 32'(busy), 1);
    chk("R5", "wr_req with data", 32'(dma_wr_req), 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (wn >= 1) break;
    end
    lone = $urandom;
    dma_wr_en = 1'b1; dma_wr_data = lone;
    @(negedge clk); dma_wr_en = 1'b0;
    wait_idle(3000);
    chk("R9", "halfwords written", 32'(wn), 33);
    bad = 0;
    for (int k = 0; k < 32; k++)
      if (wlog_d[k] !== ((k % 2 == 0) ? w[k/2][15:0] : w[k/2][31:16])) bad++;
    chk("R9", "low-first order, overflow dropped", 32'(bad), 0);
    chk("R9", "single free entry keeps low half", 32'(wlog_d[32]), 32'(lone[15:0]));
    bad = 0;
    for (int k = 0; k < 33; k++) if (wlog_a[k] != k) bad++;
    chk("R1", "pointer starts at 0 and steps", 32'(bad), 0);
    bad = 0;
    for (int k = 0; k < 32; k++) if (wlog_c[k+1] - wlog_c[k] != TICKS) bad++;
    chk("R2", "write spacing", 32'(bad), 0);
    chk("R5", "wr_req after drain", 32'(dma_wr_req), 1);

    // manual write: full drop, wrap, first-access latency
    set_mode(2'd1);
    chk("R3", "flags low in mode 1", {dma_req, dma_rd_req, dma_wr_req}, 0);
    set_addr(RSZ - 2);
    clr_logs();
    for (int i = 0; i < 33; i++) begin
      v[i] = 16'($urandom);
      @(negedge clk);
      if (i == 0) c0 = cyc;
      data_wr = 1'b1; data_in = v[i];
    end
    @(negedge clk); data_wr = 1'b0;
    wait_idle(3000);
    chk("R8", "manual write beyond full dropped", 32'(wn), 32);
    chk("R2", "first access latency", 32'(wlog_c[0] - c0), 32'(TICKS));
    bad = 0;
    for (int k = 0; k < 32; k++) begin
      if (wlog_d[k] !== v[k]) bad++;
      if (wlog_a[k] != hw_at(RSZ - 2, k)) bad++;
    end
    chk("R6", "manual data and wrapped addresses", 32'(bad), 0);
    chk("R5", "manual mode never requests", 32'(dma_wr_req), 0);

    // writes in the wrong mode are ignored
    set_mode(2'd0);
    clr_logs();
    @(negedge clk); data_wr = 1'b1; data_in = 16'hBEEF;
    dma_wr_en = 1'b1; dma_wr_data = 32'h1234_5678;
    @(negedge clk); data_wr = 1'b0; dma_wr_en = 1'b0;
    set_mode(2'd1);
    repeat (2 * TICKS + 4) @(negedge clk);
    chk("R8", "data_wr in mode 0 ignored", 32'(wn), 0);
    set_mode(2'd3);
    @(negedge clk); dma_wr_en = 1'b1; dma_wr_data = 32'hCAFE_F00D;
    @(negedge clk); dma_wr_en = 1'b0;
    set_mode(2'd0);
    chk("R9", "dma write in mode 3 wrote nothing", 32'(wn), 0);

    // flush on entering stopped
    set_mode(2'd1);
    clr_logs();
    for (int i = 0; i < 5; i++) begin
      @(negedge clk); data_wr = 1'b1; data_in = 16'(i + 7);
    end
    @(negedge clk); data_wr = 1'b0;
    set_mode(2'd0);
    chk("R11", "busy low in stopped", 32'(busy), 0);
    set_mode(2'd1);
    repeat (3 * TICKS) @(negedge clk);
    chk("R7", "flushed data never written", 32'(wn), 0);
    chk("R7", "FIFO empty after flush", 32'(busy), 0);

    // DMA read: fill, full request, underflow padding
    for (int k = 0; k < 32; k++) begin
      p[k] = 16'($urandom);
      preload(128 + k, p[k]);
    end
    q0 = 16'($urandom);
    preload(160, q0);
    set_mode(2'd0);
    set_addr(128);
    clr_logs();
    set_mode(2'd3);
    chk("R4", "rd_req low while filling", 32'(dma_rd_req), 0);
    chk("R11", "busy while filling", 32'(busy), 1);
    wait_rd_req(3000);
    chk("R4", "rd_req when full", 32'(dma_rd_req), 1);
    chk("R3", "dma_req follows rd_req", 32'(dma_req), 1);
    chk("R11", "busy low when full", 32'(busy), 0);
    chk("R4", "reads to fill", 32'(rn), 32);
    bad = 0;
    for (int k = 0; k < 31; k++) if (rlog_c[k+1] - rlog_c[k] != TICKS) bad++;
    chk("R2", "read spacing", 32'(bad), 0);
    bad = 0;
    for (int i = 0; i < 20; i++) begin
      @(negedge clk); dma_rd_en = 1'b1;
      if (i < 16) begin
        if (dma_rd_data !== word_of(p[2*i], p[2*i+1])) bad++;
      end else begin
        if (dma_rd_data !== word_of(p[31], p[31])) bad++;
      end
    end
    @(negedge clk); dma_rd_en = 1'b0;
    chk("R10", "read order and pad with last", 32'(bad), 0);
    chk("R4", "rd_req low after drain", 32'(dma_rd_req), 0);
    for (int i = 0; i < 200; i++) begin
      @(negedge clk);
      if (rn >= 33) break;
    end
    @(negedge clk); dma_rd_en = 1'b1;
    chk("R10", "single entry duplicated", dma_rd_data, word_of(q0, q0));
    @(negedge clk);
    chk("R6", "refill continued past fill block", dma_rd_data, word_of(q0, q0));
    dma_rd_en = 1'b0;
    set_mode(2'd0);
    set_mode(2'd3);
    @(negedge clk); dma_rd_en = 1'b1;
    chk("R10", "pad zero after flush", dma_rd_data, 32'h0);
    @(negedge clk); dma_rd_en = 1'b0;
    set_mode(2'd0);

    // random rounds
    for (int it = 0; it < 4; it++) begin
      int base, n;
      logic [31:0] rw [16];
      logic [15:0] rp [32];
      base = int'($urandom % RSZ);
      n = 1 + int'($urandom % 16);
      set_mode(2'd2);
      set_addr(base);
      for (int i = 0; i < n; i++) begin
        rw[i] = $urandom;
        @(negedge clk); dma_wr_en = 1'b1; dma_wr_data = rw[i];
        @(negedge clk); dma_wr_en = 1'b0;
      end
      wait_idle(3000);
      bad = 0;
      for (int k = 0; k < 2 * n; k++)
        if (bram[hw_at(base, k)] !== ((k % 2 == 0) ? rw[k/2][15:0] : rw[k/2][31:16])) bad++;
      chk("R5", "random DMA write to RAM", 32'(bad), 0);
      set_mode(2'd0);
      base = int'($urandom % RSZ);
      for (int k = 0; k < 32; k++) begin
        rp[k] = 16'($urandom);
        preload(hw_at(base, k), rp[k]);
      end
      set_addr(base);
      set_mode(2'd3);
      wait_rd_req(3000);
      bad = 0;
      for (int i = 0; i < 16; i++) begin
        @(negedge clk); dma_rd_en = 1'b1;
        if (dma_rd_data !== word_of(rp[2*i], rp[2*i+1])) bad++;
      end
      @(negedge clk); dma_rd_en = 1'b0;
      chk("R4", "random DMA read from RAM", 32'(bad), 0);
      set_mode(2'd0);
    end
  endtask

  initial begin
    fork
      run_all();
      begin
        repeat (LIMIT) @(posedge clk);
        timed_out = 1'b1;
      end
    join_any
    disable fork;
    if (timed_out) begin
      n_tests++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
    end
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule